// File: doc/BRIEF.md
# Counted Word Copy Engine

This block copies a run of words from one memory region to another. It is started by a one-cycle pulse that carries a source address, a destination address and a word count. For each word it reads from the source pointer and writes the fetched word to the destination pointer. It then moves both pointers forward by one word and lowers the count by one. It keeps stepping until the count is exhausted.

The engine drives a single synchronous word memory port. Read data comes back one cycle after the address. The port has separate read-strobe and write-strobe outputs. The engine raises a busy flag for the whole operation and pulses done once when the operation ends. The working pointers and the remaining count are always visible on outputs, so after completion a caller can read the final addresses directly.

Top module: `wcopy_engine`

## Requirements
- R1: Every word written to the destination equals the word read one cycle earlier from the matching source address, i.e. memory[dst] takes memory[src].
- R2: After each word is written, the source output and the destination output are each 4 greater than before.
- R3: A start with count N greater than zero performs exactly N reads and N writes, at addresses src+4k and dst+4k for k = 0..N-1, in increasing order.
- R4: The count output drops by exactly one after each word is written, and does not change in any other cycle of a transfer.
- R5: Each word uses one cycle with the read strobe high at the source address, followed directly by one cycle with the write strobe high at the destination address; the two strobes are never high together.
- R6: Busy is high from the cycle after an accepted start up to and including the done cycle. Done is high for exactly one cycle, which is the cycle after the last write. A count of N therefore ends with done in the (2N+1)th cycle after the start edge.
- R7: A start pulse that arrives while busy is high is ignored: the running transfer finishes with its original addresses and count.
- R8: A start with count zero makes no memory access, pulses done in the first cycle after the start edge, and leaves the source and destination outputs equal to the start values.
- R9: When done is high, the count output reads zero, and each pointer output equals its start value plus 4 times the original count.
- R10: After reset, busy, done, the read strobe and the write strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a copy |
| src_i | input | ADDR_W | Start source byte address |
| dst_i | input | ADDR_W | Start destination byte address |
| cnt_i | input | CNT_W | Number of words to copy |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid one cycle after the read address |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| src_o | output | ADDR_W | Current source pointer |
| dst_o | output | ADDR_W | Current destination pointer |
| cnt_o | output | CNT_W | Remaining word count |

## Verification
The bench builds the engine with a 12-bit address and a 4-bit count, and keeps the data width at 32. The narrow count makes the largest legal transfer (15 words) short enough to run in full, so the top of the count range is tested alongside zero, one and mid-range counts. The 12-bit address lets a 1024-word bench memory cover every address the engine can emit. This allows each write to be compared against a shadow copy of memory.

// File: rtl/wcopy_pkg.sv
package wcopy_pkg;

    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FIN   = 2'd3
    } wc_state_e;

    typedef struct packed {
        logic load;   // capture start operands
        logic step;   // advance pointers, lower count
    } wc_ctl_t;

endpackage

// File: rtl/wcopy_seq.sv
module wcopy_seq
    import wcopy_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      start_zero,
    input  logic      last_word,
    output wc_state_e state,
    output wc_ctl_t   ctl
);

    wc_state_e state_q, state_d;

    always_comb begin
        state_d  = state_q;
        ctl.load = 1'b0;
        ctl.step = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    ctl.load = 1'b1;
                    state_d  = start_zero ? ST_FIN : ST_READ;
                end
            end
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: begin
                ctl.step = 1'b1;
                state_d  = last_word ? ST_FIN : ST_READ;
            end
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READ) |=> (state_q == ST_WRITE)); // R5

endmodule

// File: rtl/wcopy_regs.sv
module wcopy_regs
    import wcopy_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  wc_ctl_t           ctl,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              last_word
);

    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORD_BYTES);
    localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
        end else if (ctl.load) begin
            src_q <= src_in;
            dst_q <= dst_in;
            cnt_q <= cnt_in;
        end else if (ctl.step) begin
            src_q <= src_q + STRIDE;
            dst_q <= dst_q + STRIDE;
            cnt_q <= cnt_q - ONE;
        end
    end

    assign last_word = (cnt_q == ONE);

    AST_STEP_NEVER_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctl.step |-> (cnt_q != '0)); // R3

endmodule

// File: rtl/wcopy_engine.sv
module wcopy_engine
    import wcopy_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_re_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [CNT_W-1:0]  cnt_o
);

    wc_state_e state;
    wc_ctl_t   ctl;
    logic      last_word;

    wcopy_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start_i),
        .start_zero (cnt_i == '0),
        .last_word  (last_word),
        .state      (state),
        .ctl        (ctl)
    );

    wcopy_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .src_in    (src_i),
        .dst_in    (dst_i),
        .cnt_in    (cnt_i),
        .src_q     (src_o),
        .dst_q     (dst_o),
        .cnt_q     (cnt_o),
        .last_word (last_word)
    );

    assign mem_re_o    = (state == ST_READ);
    assign mem_we_o    = (state == ST_WRITE);
    assign mem_addr_o  = mem_we_o ? dst_o : src_o;
    assign mem_wdata_o = mem_rdata_i;
    assign busy_o      = (state != ST_IDLE);
    assign done_o      = (state == ST_FIN);

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_re_o && mem_we_o)); // R5

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |=> (src_o == $past(src_o) + ADDR_W'(WORD_BYTES))
                  && (dst_o == $past(dst_o) + ADDR_W'(WORD_BYTES))); // R2

    AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |=> (cnt_o == $past(cnt_o) - CNT_W'(1))); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R6

    AST_DONE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cnt_o == '0)); // R9

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy_o && !done_o) |=> busy_o); // R7

endmodule

// File: tb/wcopy_engine_bench.sv
module wcopy_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 4;
    localparam int MEM_WORDS  = 1 << (ADDR_W - 2);
    localparam int WATCHDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] src_i = '0;
    logic [ADDR_W-1:0] dst_i = '0;
    logic [CNT_W-1:0]  cnt_i = '0;
    logic [ADDR_W-1:0] mem_addr_o;
    logic              mem_re_o;
    logic              mem_we_o;
    logic [DATA_W-1:0] mem_wdata_o;
    logic [DATA_W-1:0] mem_rdata_i;
    logic              busy_o;
    logic              done_o;
    logic [ADDR_W-1:0] src_o;
    logic [ADDR_W-1:0] dst_o;
    logic [CNT_W-1:0]  cnt_o;

    int n_checks = 0;
    int n_fails  = 0;
    int n_reads  = 0;
    int n_writes = 0;

    logic [DATA_W-1:0] mem     [MEM_WORDS];
    logic [DATA_W-1:0] exp_mem [MEM_WORDS];
    logic [ADDR_W+DATA_W-1:0] sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wcopy_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_wcopy_engine (
        .clk(clk), .rst(rst), .start_i(start_i), .src_i(src_i), .dst_i(dst_i),
        .cnt_i(cnt_i), .mem_addr_o(mem_addr_o), .mem_re_o(mem_re_o),
        .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o)
    );

    // synchronous word memory, read data one cycle after address
    always @(posedge clk) begin
        if (mem_we_o) mem[mem_addr_o[ADDR_W-1:2]] <= mem_wdata_o;
        mem_rdata_i <= mem[mem_addr_o[ADDR_W-1:2]];
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected writes, counts accesses
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_re_o) n_reads++;
            if (mem_we_o) begin
                logic [ADDR_W+DATA_W-1:0] item;
                n_writes++;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R3 unexpected write", longint'(mem_addr_o), 0);
                end else begin
                    item = sb_q.pop_front();
                    check(mem_addr_o == item[ADDR_W+DATA_W-1:DATA_W], "R3 write address",
                          longint'(mem_addr_o), longint'(item[ADDR_W+DATA_W-1:DATA_W]));
                    check(mem_wdata_o == item[DATA_W-1:0], "R1 write data",
                          longint'(mem_wdata_o), longint'(item[DATA_W-1:0]));
                end
            end
        end
    end

    task automatic run_copy(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d,
                            input int n, input bit poke);
        int cyc;
        int rd0;
        int wr0;
        for (int k = 0; k < n; k++) begin
            logic [ADDR_W-1:0] sa;
            logic [ADDR_W-1:0] da;
            sa = s + ADDR_W'(4*k);
            da = d + ADDR_W'(4*k);
            exp_mem[da[ADDR_W-1:2]] = exp_mem[sa[ADDR_W-1:2]];
            sb_q.push_back({da, exp_mem[da[ADDR_W-1:2]]});
        end
        rd0 = n_reads;
        wr0 = n_writes;
        @(negedge clk);
        start_i = 1'b1; src_i = s; dst_i = d; cnt_i = CNT_W'(n);
        @(negedge clk);
        start_i = 1'b0; src_i = ~s; dst_i = ~d; cnt_i = '1;
        cyc = 1;
        check(busy_o == 1'b1, "R6 busy after start", longint'(busy_o), 1);
        if (n == 0) begin
            check(done_o == 1'b1, "R8 done one cycle after zero start", longint'(done_o), 1);
            check(!mem_re_o && !mem_we_o, "R8 no access", longint'({mem_re_o, mem_we_o}), 0);
        end
        while (!done_o && cyc < 100) begin
            if (poke && cyc == 2) begin
                start_i = 1'b1; src_i = 12'h0F0; dst_i = 12'h0F8; cnt_i = 4'd1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (n >= 2 && cyc == 3) begin
                check(cnt_o == CNT_W'(n - 1), "R4 count after first word",
                      longint'(cnt_o), longint'(n - 1));
                check(src_o == s + 12'd4, "R2 source after first word",
                      longint'(src_o), longint'(s + 12'd4));
                check(dst_o == d + 12'd4, "R2 destination after first word",
                      longint'(dst_o), longint'(d + 12'd4));
            end
        end
        start_i = 1'b0;
        check(cyc == 2*n + 1, "R6 done cycle", longint'(cyc), longint'(2*n + 1));
        check(cnt_o == '0, "R9 final count", longint'(cnt_o), 0);
        check(src_o == s + ADDR_W'(4*n), "R9 final source", longint'(src_o), longint'(s + ADDR_W'(4*n)));
        check(dst_o == d + ADDR_W'(4*n), "R9 final destination", longint'(dst_o), longint'(d + ADDR_W'(4*n)));
        check(n_reads - rd0 == n, "R3 read count", longint'(n_reads - rd0), longint'(n));
        check(n_writes - wr0 == n, "R3 write count", longint'(n_writes - wr0), longint'(n));
        if (poke) check(1'b1 && (n_writes - wr0 == n), "R7 mid-run start ignored",
                        longint'(n_writes - wr0), longint'(n));
        @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0, "R6 idle after done",
              longint'({busy_o, done_o}), 0);
    endtask

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) begin
            mem[i]     = (i * 32'h0101_0101) ^ 32'hC3A5_5A3C;
            exp_mem[i] = (i * 32'h0101_0101) ^ 32'hC3A5_5A3C;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && !mem_re_o && !mem_we_o, "R10 reset state",
              longint'({busy_o, done_o, mem_re_o, mem_we_o}), 0);

        run_copy(12'h100, 12'h400, 5, 1'b0);
        run_copy(12'h200, 12'h600, 1, 1'b0);
        run_copy(12'h300, 12'h700, 0, 1'b0);   // R8
        run_copy(12'h040, 12'h800, 15, 1'b0);
        run_copy(12'h500, 12'hA00, 4, 1'b1);   // R7
        run_copy(12'h400, 12'hC00, 3, 1'b0);   // copies earlier results

        check(sb_q.size() == 0, "R3 all expected writes seen", longint'(sb_q.size()), 0);
        for (int i = 0; i < MEM_WORDS; i++) begin
            if (mem[i] !== exp_mem[i]) begin
                check(1'b0, "R1 memory image", longint'(mem[i]), longint'(exp_mem[i]));
            end
        end
        n_checks++;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule